// File: doc/BRIEF.md
# Synchronous Shift-Register Serial Port

This block implements the half-duplex synchronous mode of a serial port. One pin carries a shift clock produced by the block. A second pin carries data in either direction, least significant bit first. Each transfer moves one byte. A write to the buffer register starts a transmit. Clearing the receive-done flag while receive is enabled starts a receive. Between transfers the shift clock rests high and the data pin is released.

Each bit lasts one machine cycle, `DIV` system clocks (12 by default). The shift clock is low for the first half of the bit and high for the second half. Transmit data changes only at the start of a bit, so it is set up before the rising edge and held through the high half. Receive data is captured on the rising edge. After the eighth bit period ends, the block raises a done flag for the direction that just finished. The flag stays set until software clears it through the matching clear strobe.

Top module: `ssr_sync_serial`

## Requirements
- R1: After reset, `sclk_o` is 1, `sdata_oe_o` is 0, both done flags are 0 and `rx_data_o` is 0.
- R2: A `buf_wr_i` pulse while idle starts a transmit of `buf_wdata_i`. The transmit gives exactly 8 rising edges of `sclk_o`, and `sdata_o` presents bit 0 first and bit 7 last.
- R3: While a transfer runs, `sclk_o` is low for the first `DIV/2` cycles of each bit and high for the remaining `DIV/2`, so consecutive rising edges are `DIV` cycles apart. `sclk_o` is 1 whenever no transfer runs.
- R4: During a transmit, `sdata_o` changes only at the start of a bit, while `sclk_o` is low. It is stable from the cycle before the rising edge through the end of the high half.
- R5: `sdata_oe_o` is 1 only while a transmit is in progress, and 0 during a receive and when idle.
- R6: An `rx_flag_clr_i` pulse while idle with `rx_en_i`=1 starts a receive. The receive samples `sdata_i` at each of 8 rising edges of `sclk_o`. The first sample becomes bit 0 of `rx_data_o`.
- R7: An `rx_flag_clr_i` pulse with `rx_en_i`=0 clears the receive flag and starts no transfer: `sclk_o` stays 1 and `rx_data_o` keeps its value.
- R8: If a transfer is started by a strobe sampled at clock edge N, its done flag (`tx_done_o` or `rx_done_o`) is still 0 after edge N+8*DIV-1 and is 1 after edge N+8*DIV.
- R9: A buffer write or receive start that arrives while a transfer is running is ignored. The running transfer completes unchanged and no second transfer follows.
- R10: If `buf_wr_i` and a valid receive start arrive in the same idle cycle, the transmit wins.
- R11: `tx_flag_clr_i` and `rx_flag_clr_i` clear their flags. If a clear arrives in the same cycle as the flag is set, the set wins.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock (oscillator rate) |
| rst_ni | input | 1 | Active-low asynchronous reset |
| buf_wr_i | input | 1 | Buffer write strobe; starts a transmit |
| buf_wdata_i | input | WIDTH | Byte to transmit |
| rx_en_i | input | 1 | Receive enable level |
| rx_flag_clr_i | input | 1 | Clears receive flag; starts a receive when enabled |
| tx_flag_clr_i | input | 1 | Clears transmit flag |
| sdata_i | input | 1 | Data pin input |
| sdata_o | output | 1 | Data pin output value |
| sdata_oe_o | output | 1 | Data pin output enable |
| sclk_o | output | 1 | Shift clock, idles high |
| rx_data_o | output | WIDTH | Last received byte |
| tx_done_o | output | 1 | Transmit-done flag |
| rx_done_o | output | 1 | Receive-done flag |

## Verification
Some properties are checked by assertions on every cycle:
- the idle-high shift clock;
- the output enable being confined to transmits;
- stable transmit data across each rising edge;
- done flags rising only at the end of a transfer;
- a receive never starting without the enable;
- the direction holding steady inside a transfer.

Other behaviour can only be shown by the bench's directed scenarios:
- the byte value and LSB-first order in both directions;
- the exact cycle at which each flag appears;
- the ignoring of strobes while busy;
- transmit priority over a simultaneous receive start;
- set-over-clear on the flags.

// File: rtl/ssr_pkg.sv
package ssr_pkg;
  typedef enum logic {
    DIR_TX = 1'b0,
    DIR_RX = 1'b1
  } dir_e;
endpackage

// File: rtl/ssr_bitclk.sv
module ssr_bitclk
  import ssr_pkg::*;
#(
  parameter int DIV   = 12,
  parameter int WIDTH = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  dir_e start_dir_i,
  output logic busy_o,
  output dir_e dir_o,
  output logic sclk_o,
  output logic sample_o,
  output logic shift_o,
  output logic last_o
);
  localparam int HALF = DIV / 2;
  localparam int PH_W = (DIV > 1) ? $clog2(DIV) : 1;
  localparam int BC_W = (WIDTH > 1) ? $clog2(WIDTH) : 1;

  logic [PH_W-1:0] ph_q;
  logic [BC_W-1:0] bit_q;
  logic            busy_q;
  dir_e            dir_q;
  logic            bit_end;

  assign bit_end = busy_q && (ph_q == PH_W'(DIV - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      dir_q  <= DIR_TX;
      ph_q   <= '0;
      bit_q  <= '0;
    end else if (!busy_q) begin
      if (start_i) begin
        busy_q <= 1'b1;
        dir_q  <= start_dir_i;
        ph_q   <= '0;
        bit_q  <= '0;
      end
    end else if (bit_end) begin
      ph_q <= '0;
      if (bit_q == BC_W'(WIDTH - 1)) busy_q <= 1'b0;
      else                           bit_q  <= bit_q + 1'b1;
    end else begin
      ph_q <= ph_q + 1'b1;
    end
  end

  assign busy_o   = busy_q;
  assign dir_o    = dir_q;
  assign sclk_o   = !busy_q || (ph_q >= PH_W'(HALF));
  assign sample_o = busy_q && (ph_q == PH_W'(HALF - 1));
  assign shift_o  = bit_end;
  assign last_o   = bit_end && (bit_q == BC_W'(WIDTH - 1));

  assert_idle_high_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_q |-> sclk_o);
  assert_dir_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && $past(busy_q)) |-> $stable(dir_q));
endmodule

// File: rtl/ssr_shifter.sv
module ssr_shifter
  import ssr_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [WIDTH-1:0] load_data_i,
  input  logic             busy_i,
  input  dir_e             dir_i,
  input  logic             sample_i,
  input  logic             shift_i,
  input  logic             last_i,
  input  logic             sclk_i,
  input  logic             sdata_i,
  output logic             sdata_o,
  output logic             sdata_oe_o,
  output logic [WIDTH-1:0] rx_data_o
);
  logic [WIDTH-1:0] tx_sh_q, rx_sh_q, rx_data_q;
  logic             tx_act, rx_act;

  assign tx_act = busy_i && (dir_i == DIR_TX);
  assign rx_act = busy_i && (dir_i == DIR_RX);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                tx_sh_q <= '0;
    else if (load_i)            tx_sh_q <= load_data_i;
    else if (tx_act && shift_i) tx_sh_q <= {1'b0, tx_sh_q[WIDTH-1:1]};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rx_sh_q   <= '0;
      rx_data_q <= '0;
    end else begin
      if (rx_act && sample_i) rx_sh_q   <= {sdata_i, rx_sh_q[WIDTH-1:1]};
      if (rx_act && last_i)   rx_data_q <= rx_sh_q;
    end
  end

  assign sdata_oe_o = tx_act;
  assign sdata_o    = tx_act & tx_sh_q[0];
  assign rx_data_o  = rx_data_q;

  assert_hold_at_rise_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sdata_oe_o && sclk_i) |-> $stable(sdata_o));
  assert_release_in_rx_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_act |-> !sdata_oe_o);
endmodule

// File: rtl/ssr_flags.sv
module ssr_flags (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic busy_i,
  input  logic tx_set_i,
  input  logic rx_set_i,
  input  logic tx_clr_i,
  input  logic rx_clr_i,
  output logic tx_done_o,
  output logic rx_done_o
);
  logic tx_q, rx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_q <= 1'b0;
      rx_q <= 1'b0;
    end else begin
      if (tx_set_i)      tx_q <= 1'b1;
      else if (tx_clr_i) tx_q <= 1'b0;
      if (rx_set_i)      rx_q <= 1'b1;
      else if (rx_clr_i) rx_q <= 1'b0;
    end
  end

  assign tx_done_o = tx_q;
  assign rx_done_o = rx_q;

  assert_tx_flag_at_end_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tx_q) |-> ($past(busy_i) && !busy_i));
  assert_rx_flag_at_end_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rx_q) |-> ($past(busy_i) && !busy_i));
endmodule

// File: rtl/ssr_sync_serial.sv
module ssr_sync_serial
  import ssr_pkg::*;
#(
  parameter int DIV   = 12,
  parameter int WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             buf_wr_i,
  input  logic [WIDTH-1:0] buf_wdata_i,
  input  logic             rx_en_i,
  input  logic             rx_flag_clr_i,
  input  logic             tx_flag_clr_i,
  input  logic             sdata_i,
  output logic             sdata_o,
  output logic             sdata_oe_o,
  output logic             sclk_o,
  output logic [WIDTH-1:0] rx_data_o,
  output logic             tx_done_o,
  output logic             rx_done_o
);
  logic busy, sample, shift, last, start_tx, start_rx, sclk;
  dir_e dir, start_dir;

  // transmit has priority over a receive start in the same cycle
  assign start_tx  = buf_wr_i && !busy;
  assign start_rx  = rx_flag_clr_i && rx_en_i && !busy && !buf_wr_i;
  assign start_dir = start_tx ? DIR_TX : DIR_RX;

  ssr_bitclk #(.DIV(DIV), .WIDTH(WIDTH)) u_bitclk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_tx || start_rx),
    .start_dir_i (start_dir),
    .busy_o      (busy),
    .dir_o       (dir),
    .sclk_o      (sclk),
    .sample_o    (sample),
    .shift_o     (shift),
    .last_o      (last)
  );

  ssr_shifter #(.WIDTH(WIDTH)) u_shifter (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (start_tx),
    .load_data_i (buf_wdata_i),
    .busy_i      (busy),
    .dir_i       (dir),
    .sample_i    (sample),
    .shift_i     (shift),
    .last_i      (last),
    .sclk_i      (sclk),
    .sdata_i     (sdata_i),
    .sdata_o     (sdata_o),
    .sdata_oe_o  (sdata_oe_o),
    .rx_data_o   (rx_data_o)
  );

  ssr_flags u_flags (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .busy_i    (busy),
    .tx_set_i  (last && (dir == DIR_TX)),
    .rx_set_i  (last && (dir == DIR_RX)),
    .tx_clr_i  (tx_flag_clr_i),
    .rx_clr_i  (rx_flag_clr_i),
    .tx_done_o (tx_done_o),
    .rx_done_o (rx_done_o)
  );

  assign sclk_o = sclk;

  assert_rx_needs_en_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(busy) && dir == DIR_RX) |-> $past(rx_en_i));
  assert_tx_wins_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(busy) && $past(buf_wr_i)) |-> (dir == DIR_TX));
  assert_oe_only_tx_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sdata_oe_o |-> (busy && dir == DIR_TX));
endmodule

// File: tb/ssr_sync_serial_bench.sv
module ssr_sync_serial_bench;
  localparam int DIV   = 12;
  localparam int WIDTH = 8;
  localparam int XFER  = 8 * DIV;

  logic             clk = 1'b0;
  logic             rst_ni = 1'b0;
  logic             buf_wr_i = 1'b0;
  logic [WIDTH-1:0] buf_wdata_i = '0;
  logic             rx_en_i = 1'b0;
  logic             rx_flag_clr_i = 1'b0;
  logic             tx_flag_clr_i = 1'b0;
  logic             sdata_i = 1'b0;
  logic             sdata_o, sdata_oe_o, sclk_o, tx_done_o, rx_done_o;
  logic [WIDTH-1:0] rx_data_o;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int rises = 0;
  int last_rise = 0;
  int bad_gap = 0;
  logic [WIDTH-1:0] cap = '0;
  logic [WIDTH-1:0] pat = '0;
  int rx_idx = 0;
  logic rx_drv = 1'b0;

  always #2.5 clk = ~clk;

  ssr_sync_serial #(.DIV(DIV), .WIDTH(WIDTH)) u_ssr_sync_serial (
    .clk_i(clk), .rst_ni(rst_ni), .buf_wr_i(buf_wr_i), .buf_wdata_i(buf_wdata_i),
    .rx_en_i(rx_en_i), .rx_flag_clr_i(rx_flag_clr_i), .tx_flag_clr_i(tx_flag_clr_i),
    .sdata_i(sdata_i), .sdata_o(sdata_o), .sdata_oe_o(sdata_oe_o), .sclk_o(sclk_o),
    .rx_data_o(rx_data_o), .tx_done_o(tx_done_o), .rx_done_o(rx_done_o)
  );

  always @(posedge clk) cyc++;

  // external device: capture on rising shift clock, measure spacing
  always @(posedge sclk_o) begin
    if (rises > 0 && (cyc - last_rise) != DIV) bad_gap++;
    last_rise = cyc;
    rises++;
    cap = {sdata_o, cap[WIDTH-1:1]};
  end

  // external device: present next receive bit on falling shift clock
  always @(negedge sclk_o) begin
    if (rx_drv && rx_idx < WIDTH) begin
      sdata_i = pat[rx_idx];
      rx_idx++;
    end
  end

  task automatic check(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic clear_flags();
    @(negedge clk);
    tx_flag_clr_i = 1'b1;
    rx_en_i = 1'b0;
    rx_flag_clr_i = 1'b1;
    @(negedge clk);
    tx_flag_clr_i = 1'b0;
    rx_flag_clr_i = 1'b0;
  endtask

  task automatic t_reset();
    check(sclk_o == 1'b1, "R1 sclk", sclk_o, 1);
    check(sdata_oe_o == 1'b0, "R1 oe", sdata_oe_o, 0);
    check(tx_done_o == 1'b0 && rx_done_o == 1'b0, "R1 flags", {tx_done_o, rx_done_o}, 0);
    check(rx_data_o == '0, "R1 rx_data", rx_data_o, 0);
  endtask

  task automatic t_tx(input logic [WIDTH-1:0] b);
    int oe_lost = 0;
    clear_flags();
    rises = 0; bad_gap = 0;
    buf_wr_i = 1'b1; buf_wdata_i = b;
    @(negedge clk);
    buf_wr_i = 1'b0;
    check(sdata_oe_o == 1'b1 && sclk_o == 1'b0, "R5 tx start", {sdata_oe_o, sclk_o}, 2);
    for (int i = 1; i < XFER; i++) begin
      @(negedge clk);
      if (!sdata_oe_o) oe_lost++;
    end
    check(tx_done_o == 1'b0, "R8 tx early", tx_done_o, 0);
    check(oe_lost == 0, "R5 oe held", oe_lost, 0);
    @(negedge clk);
    check(tx_done_o == 1'b1, "R8 tx flag", tx_done_o, 1);
    check(cap == b, "R2 tx byte", cap, b);
    check(rises == WIDTH, "R2 rises", rises, WIDTH);
    check(bad_gap == 0, "R3 period", bad_gap, 0);
    check(sclk_o == 1'b1 && sdata_oe_o == 1'b0, "R3 idle", {sclk_o, sdata_oe_o}, 2);
  endtask

  task automatic t_rx(input logic [WIDTH-1:0] b);
    int oe_seen = 0;
    clear_flags();
    rises = 0; bad_gap = 0; pat = b; rx_idx = 0; rx_drv = 1'b1;
    rx_en_i = 1'b1; rx_flag_clr_i = 1'b1;
    @(negedge clk);
    rx_flag_clr_i = 1'b0;
    for (int i = 1; i < XFER; i++) begin
      if (sdata_oe_o) oe_seen++;
      @(negedge clk);
    end
    check(rx_done_o == 1'b0, "R8 rx early", rx_done_o, 0);
    @(negedge clk);
    rx_drv = 1'b0;
    check(rx_done_o == 1'b1, "R8 rx flag", rx_done_o, 1);
    check(rx_data_o == b, "R6 rx byte", rx_data_o, b);
    check(rises == WIDTH, "R6 rises", rises, WIDTH);
    check(oe_seen == 0, "R5 rx released", oe_seen, 0);
    check(bad_gap == 0, "R3 rx period", bad_gap, 0);
    rx_en_i = 1'b0;
  endtask

  task automatic t_rx_disabled();
    logic [WIDTH-1:0] keep;
    int low = 0;
    keep = rx_data_o;
    rises = 0;
    @(negedge clk);
    rx_en_i = 1'b0; rx_flag_clr_i = 1'b1;
    @(negedge clk);
    rx_flag_clr_i = 1'b0;
    for (int i = 0; i < 3 * DIV; i++) begin
      if (!sclk_o) low++;
      @(negedge clk);
    end
    check(low == 0 && rises == 0, "R7 no clock", low + rises, 0);
    check(rx_done_o == 1'b0, "R7 flag cleared", rx_done_o, 0);
    check(rx_data_o == keep, "R7 data kept", rx_data_o, keep);
  endtask

  task automatic t_busy_ignore();
    clear_flags();
    rises = 0;
    buf_wr_i = 1'b1; buf_wdata_i = 8'h96;
    @(negedge clk);
    buf_wr_i = 1'b0;
    repeat (2 * DIV) @(negedge clk);
    buf_wr_i = 1'b1; buf_wdata_i = 8'h11;
    rx_en_i = 1'b1; rx_flag_clr_i = 1'b1;
    @(negedge clk);
    buf_wr_i = 1'b0; rx_flag_clr_i = 1'b0; rx_en_i = 1'b0;
    repeat (XFER - 2 * DIV - 1) @(negedge clk);
    check(tx_done_o == 1'b1, "R9 tx completes", tx_done_o, 1);
    repeat (2 * DIV) @(negedge clk);
    check(cap == 8'h96, "R9 byte unchanged", cap, 8'h96);
    check(rises == WIDTH, "R9 no second transfer", rises, WIDTH);
    check(rx_done_o == 1'b0, "R9 no rx", rx_done_o, 0);
  endtask

  task automatic t_priority();
    clear_flags();
    rises = 0;
    buf_wr_i = 1'b1; buf_wdata_i = 8'h4E;
    rx_en_i = 1'b1; rx_flag_clr_i = 1'b1;
    @(negedge clk);
    buf_wr_i = 1'b0; rx_flag_clr_i = 1'b0; rx_en_i = 1'b0;
    check(sdata_oe_o == 1'b1, "R10 tx chosen", sdata_oe_o, 1);
    repeat (XFER) @(negedge clk);
    check(tx_done_o == 1'b1 && rx_done_o == 1'b0, "R10 flags", {tx_done_o, rx_done_o}, 2);
    check(cap == 8'h4E, "R10 byte", cap, 8'h4E);
  endtask

  task automatic t_set_wins();
    clear_flags();
    buf_wr_i = 1'b1; buf_wdata_i = 8'h81;
    @(negedge clk);
    buf_wr_i = 1'b0;
    repeat (XFER - 1) @(negedge clk);
    tx_flag_clr_i = 1'b1;
    @(negedge clk);
    tx_flag_clr_i = 1'b0;
    check(tx_done_o == 1'b1, "R11 set wins", tx_done_o, 1);
    tx_flag_clr_i = 1'b1;
    @(negedge clk);
    tx_flag_clr_i = 1'b0;
    check(tx_done_o == 1'b0, "R11 tx clear", tx_done_o, 0);
    check(cap == 8'h81, "R2 edge bits", cap, 8'h81);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_ni = 1'b1;
    @(negedge clk);
    t_reset();
    t_tx(8'hA5);
    t_tx(8'h3C);
    t_tx(8'h01);
    t_rx(8'hC3);
    t_rx(8'h5A);
    t_rx_disabled();
    t_busy_ignore();
    t_priority();
    t_set_wins();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule